// File: doc/BRIEF.md
# Burst-of-Four Quad-Data-Rate SRAM Model

This block is a synthesizable behavioural model of a synchronous SRAM with separate read and write ports. Both data buses run at double data rate, and every access moves exactly four beats. Double-rate transfer is modelled with paired phases: each port carries a rise half and a fall half. One clock cycle therefore moves two beats, and one burst takes two cycles. The array word is four bus-words wide. Each address names one full word, so the address is two bits narrower than the beat-level depth.

A write command registers its address. The four write beats follow on the next two clock edges, each with its own byte-lane enables. On the second data edge the beats are merged into the stored word and committed in one operation. A read command fetches one array word, which is then sent out as four sequential beats after a latency selected by a parameter.

Reads and writes may be issued in the same cycle. A read that hits a write still being gathered sees the beats captured so far, merged by byte lane.

Top module: `qb4_sram`

## Requirements
- R1: A write command sampled at edge E0 registers `wr_addr`. Beat 0 (`wd_rise`) and beat 1 (`wd_fall`) are sampled at edge E0+1. Beat 2 (`wd_rise`) and beat 3 (`wd_fall`) are sampled at edge E0+2. All four beats are committed to the addressed word in one operation at E0+2.
- R2: Each beat carries its own byte enables (`wbe_rise` for even beats, `wbe_fall` for odd beats). Lane l covers bits [l*DW/NB +: DW/NB] of the beat. An enable of 1 writes that lane, and a lane whose enable is 0 keeps its previous content.
- R3: A read returns the stored word as four beats. In the first output cycle, `rq_rise` holds beat 0 and `rq_fall` holds beat 1. In the next cycle they hold beat 2 and beat 3.
- R4: A read command sampled at edge R0 drives beats 0 and 1 on the outputs after edge R0+2 when `LONG_LAT`=1, and after edge R0+1 when `LONG_LAT`=0.
- R5: `rq_valid` is 1 in exactly the two output cycles of each accepted read. `rq_rise` and `rq_fall` are zero whenever `rq_valid` is 0.
- R6: A read of address A, accepted at the edge where the last two beats of a write to A are sampled, returns the fully written word.
- R7: A read of address A, accepted at the edge where beats 0 and 1 of a write to A are sampled, returns those two beats merged under their enables and the old content for beats 2 and 3.
- R8: A read of address A, accepted at the same edge as a write command to A, returns the content from before that write.
- R9: A write command at the edge where beats 0 and 1 of an active burst are sampled is ignored. A read command at the edge right after an accepted read is ignored.
- R10: While `rst_n` is low, `rq_valid` is 0, the read data outputs are zero, and no command is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read command |
| rd_addr | input | AW | Read word address |
| wr_req | input | 1 | Write command |
| wr_addr | input | AW | Write word address |
| wd_rise | input | DW | Write beat 0 or 2 |
| wd_fall | input | DW | Write beat 1 or 3 |
| wbe_rise | input | NB | Byte enables for the rise beat |
| wbe_fall | input | NB | Byte enables for the fall beat |
| rq_rise | output | DW | Read beat 0 or 2 |
| rq_fall | output | DW | Read beat 1 or 3 |
| rq_valid | output | 1 | Read data valid |

## Verification
A write beat pair is due at the edge right after its command, and the second pair at the edge after that. Read beats 0 and 1 appear one or two edges after the read command, depending on latency, and beats 2 and 3 follow one edge later. The bench runs one instance of each latency from the same stimulus. When it issues a read, a model built from the requirements computes the expected word, and the bench files each beat pair under the edge number at which it is due for each instance. After every edge, at the falling clock, the bench compares both instances' outputs with the entry for that edge. Cycles with no read expect valid low and zero data.

// File: rtl/qb4_pkg.sv
package qb4_pkg;
  typedef enum logic [1:0] {
    WP_IDLE = 2'd0,
    WP_LO   = 2'd1,
    WP_HI   = 2'd2
  } wph_t;
endpackage

// File: rtl/qb4_wr_gather.sv
module qb4_wr_gather import qb4_pkg::*; #(
  parameter int DW = 18,
  parameter int NB = 2,
  parameter int AW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_req,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wd_rise,
  input  logic [DW-1:0]   wd_fall,
  input  logic [NB-1:0]   wbe_rise,
  input  logic [NB-1:0]   wbe_fall,
  output logic            pend,
  output logic [AW-1:0]   pend_addr,
  output logic [4*DW-1:0] cap_data,
  output logic [4*NB-1:0] cap_be,
  output logic            commit
);
  wph_t            ph_q, ph_n;
  logic [AW-1:0]   addr_q;
  logic [2*DW-1:0] lo_data_q;
  logic [2*NB-1:0] lo_be_q;
  logic            addr_en, lo_en;

  always_comb begin
    case (ph_q)
      WP_LO:   ph_n = WP_HI;
      default: ph_n = wr_req ? WP_LO : WP_IDLE;
    endcase
    addr_en = wr_req && (ph_q != WP_LO);
    lo_en   = (ph_q == WP_LO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= WP_IDLE;
      addr_q    <= '0;
      lo_data_q <= '0;
      lo_be_q   <= '0;
    end else begin
      ph_q <= ph_n;
      if (addr_en) addr_q <= wr_addr;
      if (lo_en) begin
        lo_data_q <= {wd_fall, wd_rise};
        lo_be_q   <= {wbe_fall, wbe_rise};
      end
    end
  end

  always_comb begin
    case (ph_q)
      WP_LO: begin
        cap_data = {{(2*DW){1'b0}}, wd_fall, wd_rise};
        cap_be   = {{(2*NB){1'b0}}, wbe_fall, wbe_rise};
      end
      WP_HI: begin
        cap_data = {wd_fall, wd_rise, lo_data_q};
        cap_be   = {wbe_fall, wbe_rise, lo_be_q};
      end
      default: begin
        cap_data = '0;
        cap_be   = '0;
      end
    endcase
  end

  assign pend      = (ph_q != WP_IDLE);
  assign pend_addr = addr_q;
  assign commit    = (ph_q == WP_HI);

  // R9
  wr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == WP_LO) |=> (ph_q == WP_HI));

  // R1
  commit_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
endmodule

// File: rtl/qb4_array.sv
module qb4_array #(
  parameter int DW = 18,
  parameter int NB = 2,
  parameter int AW = 4
) (
  input  logic            clk,
  input  logic [AW-1:0]   rd_addr,
  input  logic            pend,
  input  logic [AW-1:0]   pend_addr,
  input  logic [4*DW-1:0] cap_data,
  input  logic [4*NB-1:0] cap_be,
  input  logic            commit,
  output logic [4*DW-1:0] rd_word
);
  localparam int DEPTH = 1 << AW;
  localparam int LW    = DW / NB;
  localparam int NL    = 4 * NB;

  logic [4*DW-1:0] mem [DEPTH];
  logic [4*DW-1:0] wr_word;
  logic            hit;

  function automatic logic [4*DW-1:0] lane_merge(
    input logic [4*DW-1:0] base,
    input logic [4*DW-1:0] nw,
    input logic [NL-1:0]   en);
    logic [4*DW-1:0] r;
    r = base;
    for (int i = 0; i < NL; i++)
      if (en[i]) r[i*LW +: LW] = nw[i*LW +: LW];
    return r;
  endfunction

  always_comb begin
    wr_word = lane_merge(mem[pend_addr], cap_data, cap_be);
    hit     = pend && (pend_addr == rd_addr);
    rd_word = hit ? lane_merge(mem[rd_addr], cap_data, cap_be) : mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (commit) mem[pend_addr] <= wr_word;
  end
endmodule

// File: rtl/qb4_rd_serial.sv
module qb4_rd_serial #(
  parameter int DW       = 18,
  parameter bit LONG_LAT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_acc,
  input  logic [4*DW-1:0] rd_word,
  output logic [DW-1:0]   rq_rise,
  output logic [DW-1:0]   rq_fall,
  output logic            rq_valid
);
  logic [4*DW-1:0] w0_q, src_word;
  logic            v0_q, src_vld;
  logic            hi_q, hi_n;
  logic [DW-1:0]   rise_n, fall_n;
  logic            vld_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w0_q <= '0;
      v0_q <= 1'b0;
    end else begin
      v0_q <= rd_acc;
      if (rd_acc) w0_q <= rd_word;
    end
  end

  generate
    if (LONG_LAT) begin : g_long
      logic [4*DW-1:0] w1_q;
      logic            v1_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          w1_q <= '0;
          v1_q <= 1'b0;
        end else begin
          v1_q <= v0_q;
          if (v0_q) w1_q <= w0_q;
        end
      end
      assign src_word = w1_q;
      assign src_vld  = v1_q;
    end else begin : g_short
      assign src_word = w0_q;
      assign src_vld  = v0_q;
    end
  endgenerate

  always_comb begin
    hi_n   = 1'b0;
    vld_n  = 1'b0;
    rise_n = '0;
    fall_n = '0;
    if (src_vld) begin
      vld_n  = 1'b1;
      hi_n   = 1'b1;
      rise_n = src_word[0*DW +: DW];
      fall_n = src_word[1*DW +: DW];
    end else if (hi_q) begin
      vld_n  = 1'b1;
      rise_n = src_word[2*DW +: DW];
      fall_n = src_word[3*DW +: DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q     <= 1'b0;
      rq_valid <= 1'b0;
      rq_rise  <= '0;
      rq_fall  <= '0;
    end else begin
      hi_q     <= hi_n;
      rq_valid <= vld_n;
      rq_rise  <= rise_n;
      rq_fall  <= fall_n;
    end
  end

  // R5
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rq_valid) |=> rq_valid);

  // R9
  src_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_vld |=> !src_vld);
endmodule

// File: rtl/qb4_sram.sv
module qb4_sram #(
  parameter int DW       = 18,
  parameter int NB       = 2,
  parameter int AW       = 4,
  parameter bit LONG_LAT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wd_rise,
  input  logic [DW-1:0] wd_fall,
  input  logic [NB-1:0] wbe_rise,
  input  logic [NB-1:0] wbe_fall,
  output logic [DW-1:0] rq_rise,
  output logic [DW-1:0] rq_fall,
  output logic          rq_valid
);
  logic            pend, commit, rd_acc, rbusy_q;
  logic [AW-1:0]   pend_addr;
  logic [4*DW-1:0] cap_data, rd_word;
  logic [4*NB-1:0] cap_be;

  assign rd_acc = rd_req && !rbusy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rbusy_q <= 1'b0;
    else        rbusy_q <= rd_acc;
  end

  qb4_wr_gather #(.DW(DW), .NB(NB), .AW(AW)) u_gather (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
    .wd_rise(wd_rise), .wd_fall(wd_fall), .wbe_rise(wbe_rise), .wbe_fall(wbe_fall),
    .pend(pend), .pend_addr(pend_addr), .cap_data(cap_data), .cap_be(cap_be),
    .commit(commit)
  );

  qb4_array #(.DW(DW), .NB(NB), .AW(AW)) u_array (
    .clk(clk), .rd_addr(rd_addr), .pend(pend), .pend_addr(pend_addr),
    .cap_data(cap_data), .cap_be(cap_be), .commit(commit), .rd_word(rd_word)
  );

  qb4_rd_serial #(.DW(DW), .LONG_LAT(LONG_LAT)) u_serial (
    .clk(clk), .rst_n(rst_n), .rd_acc(rd_acc), .rd_word(rd_word),
    .rq_rise(rq_rise), .rq_fall(rq_fall), .rq_valid(rq_valid)
  );

  // R9
  rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> !rd_acc);
endmodule

// File: tb/tb_qb4_sram.sv
module tb_qb4_sram;
  localparam int DW = 18;
  localparam int NB = 2;
  localparam int AW = 4;
  localparam int LW = DW / NB;
  localparam int NE = 4096;

  logic clk, rst_n;
  logic rd_req, wr_req;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] wd_rise, wd_fall;
  logic [NB-1:0] wbe_rise, wbe_fall;
  logic [DW-1:0] l_rise, l_fall, s_rise, s_fall;
  logic l_vld, s_vld;

  qb4_sram #(.DW(DW), .NB(NB), .AW(AW), .LONG_LAT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .wr_req(wr_req), .wr_addr(wr_addr), .wd_rise(wd_rise), .wd_fall(wd_fall),
    .wbe_rise(wbe_rise), .wbe_fall(wbe_fall),
    .rq_rise(l_rise), .rq_fall(l_fall), .rq_valid(l_vld));

  qb4_sram #(.DW(DW), .NB(NB), .AW(AW), .LONG_LAT(1'b0)) dut_short (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .wr_req(wr_req), .wr_addr(wr_addr), .wd_rise(wd_rise), .wd_fall(wd_fall),
    .wbe_rise(wbe_rise), .wbe_fall(wbe_fall),
    .rq_rise(s_rise), .rq_fall(s_fall), .rq_valid(s_vld));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  int n_chk = 0, n_fail = 0;
  bit checking = 0, finished = 0;
  string cur = "R1";

  logic [2*DW:0] expL [NE];
  logic [2*DW:0] expS [NE];
  logic [4*DW-1:0] mdl [1<<AW];

  int wst = 0, rbusy = 0;
  int mwa = 0;
  logic [2*DW-1:0] m_lo;
  logic [2*NB-1:0] m_lo_be;
  logic [DW-1:0] p_dr, p_df;
  logic [NB-1:0] p_mr, p_mf;

  function automatic logic [DW-1:0] gen(int a, int b, int pass);
    return DW'((a * 37 + b * 11 + pass * 101 + 5) % (1 << DW));
  endfunction

  function automatic logic [4*DW-1:0] put(logic [4*DW-1:0] w, int beat,
                                          logic [DW-1:0] d, logic [NB-1:0] m);
    for (int l = 0; l < NB; l++)
      if (m[l]) w[beat*DW + l*LW +: LW] = d[l*LW +: LW];
    return w;
  endfunction

  always @(negedge clk) begin
    if (checking && !finished) begin
      n_chk += 2;
      if ({l_vld, l_fall, l_rise} !== expL[cyc]) begin
        n_fail++;
        $display("FAIL %s/R4/R5 long cyc=%0d actual=%h expected=%h", cur, cyc,
                 {l_vld, l_fall, l_rise}, expL[cyc]);
      end
      if ({s_vld, s_fall, s_rise} !== expS[cyc]) begin
        n_fail++;
        $display("FAIL %s/R4/R5 short cyc=%0d actual=%h expected=%h", cur, cyc,
                 {s_vld, s_fall, s_rise}, expS[cyc]);
      end
    end
  end

  task automatic tick(bit rd, int ra, bit wr, int wa,
                      logic [DW-1:0] dr, logic [DW-1:0] df,
                      logic [NB-1:0] mr, logic [NB-1:0] mf);
    int k;
    logic [4*DW-1:0] w;
    @(negedge clk);
    rd_req = rd; rd_addr = AW'(ra); wr_req = wr; wr_addr = AW'(wa);
    wd_rise = dr; wd_fall = df; wbe_rise = mr; wbe_fall = mf;
    k = cyc + 1;
    if (wst == 2) begin  // R1 commit of all four beats
      w = mdl[mwa];
      w = put(w, 0, m_lo[DW-1:0], m_lo_be[NB-1:0]);
      w = put(w, 1, m_lo[2*DW-1:DW], m_lo_be[2*NB-1:NB]);
      w = put(w, 2, dr, mr);
      w = put(w, 3, df, mf);
      mdl[mwa] = w;
    end
    if (rd && rbusy == 0) begin
      w = mdl[ra];
      if (wst == 1 && mwa == ra) begin  // R7 partial merge
        w = put(w, 0, dr, mr);
        w = put(w, 1, df, mf);
      end
      expS[k+1] = {1'b1, w[DW +: DW], w[0 +: DW]};
      expS[k+2] = {1'b1, w[3*DW +: DW], w[2*DW +: DW]};
      expL[k+2] = {1'b1, w[DW +: DW], w[0 +: DW]};
      expL[k+3] = {1'b1, w[3*DW +: DW], w[2*DW +: DW]};
    end
    if (wst == 1) begin
      m_lo = {df, dr};
      m_lo_be = {mf, mr};
    end
    rbusy = (rbusy == 0 && rd) ? 1 : 0;
    if (wst == 1) wst = 2;
    else if (wr) begin wst = 1; mwa = wa; end
    else wst = 0;
  endtask

  task automatic pair(bit w, int wa, int pass, logic [4*NB-1:0] m,
                      bit rA, int raA, bit rB, int raB, bit wB, int waB);
    logic [DW-1:0] b0, b1;
    b0 = w ? gen(wa, 0, pass) : '0;
    b1 = w ? gen(wa, 1, pass) : '0;
    tick(rA, raA, w, wa, p_dr, p_df, p_mr, p_mf);
    tick(rB, raB, wB, waB, b0, b1, w ? m[NB-1:0] : '0, w ? m[2*NB-1:NB] : '0);
    if (w) begin
      p_dr = gen(wa, 2, pass); p_df = gen(wa, 3, pass);
      p_mr = m[3*NB-1:2*NB];   p_mf = m[4*NB-1:3*NB];
    end else begin
      p_dr = '0; p_df = '0; p_mr = '0; p_mf = '0;
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NE; i++) begin expL[i] = '0; expS[i] = '0; end
    p_dr = '0; p_df = '0; p_mr = '0; p_mf = '0;
    m_lo = '0; m_lo_be = '0;
    rst_n = 1'b0; rd_req = 0; wr_req = 0; rd_addr = '0; wr_addr = '0;
    wd_rise = '0; wd_fall = '0; wbe_rise = '0; wbe_fall = '0;
    repeat (3) @(negedge clk);
    // R10: outputs idle while reset is held
    n_chk += 2;
    if ({l_vld, l_fall, l_rise} !== '0) begin
      n_fail++; $display("FAIL R10 long actual=%h expected=0", {l_vld, l_fall, l_rise});
    end
    if ({s_vld, s_fall, s_rise} !== '0) begin
      n_fail++; $display("FAIL R10 short actual=%h expected=0", {s_vld, s_fall, s_rise});
    end
    rst_n = 1'b1;
    checking = 1;

    cur = "R1";
    for (int a = 0; a < 16; a++) pair(1, a, 0, '1, 0, 0, 0, 0, 0, 0);
    pair(0, 0, 0, '0, 0, 0, 0, 0, 0, 0);

    cur = "R3";
    for (int a = 0; a < 16; a++) pair(0, 0, 0, '0, 1, a, 0, 0, 0, 0);

    cur = "R2";
    for (int p = 0; p < 256; p++)
      pair(1, p % 16, p + 1, 8'(p), 1, (p * 5 + 3) % 16, 0, 0, 0, 0);
    pair(0, 0, 0, '0, 0, 0, 0, 0, 0, 0);

    cur = "R6";
    pair(1, 3, 300, 8'hA5, 0, 0, 0, 0, 0, 0);
    pair(0, 0, 0, '0, 1, 3, 0, 0, 0, 0);
    pair(0, 0, 0, '0, 0, 0, 0, 0, 0, 0);

    cur = "R7";
    pair(1, 4, 301, 8'h3C, 0, 0, 1, 4, 0, 0);
    cur = "R9";
    pair(0, 0, 0, '0, 1, 5, 0, 0, 0, 0);  // read one cycle after accepted read
    pair(0, 0, 0, '0, 0, 0, 0, 0, 0, 0);

    cur = "R8";
    pair(1, 6, 302, 8'hFF, 1, 6, 0, 0, 0, 0);
    pair(0, 0, 0, '0, 0, 0, 0, 0, 0, 0);
    pair(0, 0, 0, '0, 1, 6, 0, 0, 0, 0);

    cur = "R9";
    pair(1, 7, 303, 8'hFF, 0, 0, 0, 0, 1, 9);  // write at beat 0/1 edge
    pair(0, 0, 0, '0, 1, 9, 0, 0, 0, 0);
    pair(0, 0, 0, '0, 1, 7, 0, 0, 0, 0);

    cur = "R3";
    for (int a = 0; a < 16; a++) pair(0, 0, 0, '0, 1, a, 0, 0, 0, 0);
    cur = "R5";
    for (int i = 0; i < 4; i++) pair(0, 0, 0, '0, 0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule